// File: doc/BRIEF.md
# Current-Sense ADC Control Register Bank

This block is the register front end of a current-sense converter. A host reaches it over a simple byte-wide bus made of an 8-bit offset, a write strobe, write data and a combinational read-data return. Through this bus the host sets up the converter: operating mode with trim, input channel, decimation, settle delay and sample averaging. It then switches the peripheral on and asks for a conversion. The block reports progress in a status byte, raises a one-cycle interrupt when a result is ready, and returns the 16-bit result as two bytes.

The converter itself is outside this block. This block gives it a one-cycle start pulse for each sample it needs. The converter answers each start with a one-cycle done pulse that carries a 16-bit code. When averaging is on, the block asks for 2^N samples in turn, adds them up and reports their mean. A reset-behaviour register is protected: a write to it takes effect only right after a key write.

Top module: `cadc_regbank`

## Requirements
- R1: Offsets 0x01, 0x04 and 0x05 are read-only and read 0x01, 0x08 and 0x03. Writes to them change nothing.
- R2: After reset, the following all read 0: every control register, the status byte, the result bytes and the protected register. The outputs irq and conv_start are 0.
- R3: The registers at 0x40 (mode), 0x50 (decimation), 0x51 (settle delay) and 0x5A (averaging exponent) read back the last byte written. The register at 0x5B keeps only bit 7 (averaging on) and reads 0x80 or 0x00. The register at 0x46 keeps only bit 7 (peripheral on).
- R4: The channel register at 0x48 takes a written value only if that value is 0, 1, 3, 5 or 6. A write of any other value leaves the stored channel unchanged.
- R5: The status byte at 0x08 has these fields: bit 0 is end-of-conversion, bit 1 is request-pending, and bits 6:4 copy mode bits 5:3 (the operating mode). All other bits read 0. Bits 0 and 1 are never both set.
- R6: A write to 0x52 with bit 7 set starts a conversion, but only when the peripheral is on and no request is pending. A start sets request-pending, clears end-of-conversion and gives a one-cycle conv_start. Bit 7 of 0x52 reads back request-pending. A request made while one is pending is ignored.
- R7: A request made while the peripheral is off is ignored: no conv_start is given and the status does not change.
- R8: A conversion takes 2^N samples. N is bits 2:0 of 0x5A when 0x5B bit 7 is set, and 0 otherwise. Each sample gets its own conv_start. The result is the sum of the sampled codes shifted right by N. When the conversion finishes, status bits 1:0 read 01.
- R9: irq is high for exactly one cycle, in the cycle where end-of-conversion becomes set.
- R10: Writing 0x46 with bit 7 clear turns the peripheral off. It also clears request-pending and end-of-conversion. A done pulse that arrives afterwards is ignored and leaves the result unchanged.
- R11: The result low byte reads at 0x60 and the high byte at 0x61.
- R12: Writing 0xA5 to 0xD0 arms a single write to the protected register at 0xDA, whose bit 2 selects follow-warm-reset. The next bus write uses up the arming, whatever its offset. A write to 0xDA when not armed is ignored.
- R13: Offsets that are not defined read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| conv_start | output | 1 | One-cycle pulse asking the converter for a sample |
| conv_done | input | 1 | One-cycle pulse from the converter: a sample is ready |
| conv_code | input | 16 | Sample code, valid with conv_done |
| irq | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
The hardest case to reach is an abort with a sample still in flight. The bench's converter model answers each start only after several cycles. The test turns the peripheral off in the cycle right after the request, then lets the late done pulse arrive. It then checks that status, result and interrupt count are all unchanged. A second hard case is an arming that a write to another register uses up. The test puts a write to the settle-delay register between the key write and the protected write, then reads the protected register back.

// File: rtl/cadc_pkg.sv
package cadc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_REV     = 8'h01;
  localparam logic [ADDR_W-1:0] A_TYPE    = 8'h04;
  localparam logic [ADDR_W-1:0] A_SUBTYPE = 8'h05;
  localparam logic [ADDR_W-1:0] A_STATUS  = 8'h08;
  localparam logic [ADDR_W-1:0] A_MODE    = 8'h40;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 8'h46;
  localparam logic [ADDR_W-1:0] A_CHAN    = 8'h48;
  localparam logic [ADDR_W-1:0] A_DECIM   = 8'h50;
  localparam logic [ADDR_W-1:0] A_SETTLE  = 8'h51;
  localparam logic [ADDR_W-1:0] A_REQ     = 8'h52;
  localparam logic [ADDR_W-1:0] A_AVGN    = 8'h5A;
  localparam logic [ADDR_W-1:0] A_AVGEN   = 8'h5B;
  localparam logic [ADDR_W-1:0] A_RES_LO  = 8'h60;
  localparam logic [ADDR_W-1:0] A_RES_HI  = 8'h61;
  localparam logic [ADDR_W-1:0] A_KEY     = 8'hD0;
  localparam logic [ADDR_W-1:0] A_PROT    = 8'hDA;

  localparam logic [DATA_W-1:0] ID_REV     = 8'h01;
  localparam logic [DATA_W-1:0] ID_TYPE    = 8'h08;
  localparam logic [DATA_W-1:0] ID_SUBTYPE = 8'h03;
  localparam logic [DATA_W-1:0] KEY_VALUE  = 8'hA5;
endpackage

// File: rtl/cadc_cfg_regs.sv
module cadc_cfg_regs
  import cadc_pkg::*;
#(
  parameter int CH_W = 3,
  parameter logic [(1<<CH_W)-1:0] CH_OK_MASK = 8'b0110_1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] decim_q,
  output logic [DATA_W-1:0] settle_q,
  output logic [DATA_W-1:0] avgn_q,
  output logic              avgen_q,
  output logic [CH_W-1:0]   chan_q
);
  localparam int NCH = 1 << CH_W;

  logic [DATA_W-1:0] mode_d, decim_d, settle_d, avgn_d;
  logic              avgen_d;
  logic [CH_W-1:0]   chan_d;
  logic              chan_ok;

  always_comb begin
    chan_ok = (32'(wdata) < NCH) && CH_OK_MASK[wdata[CH_W-1:0]];
  end

  always_comb begin
    mode_d   = mode_q;
    decim_d  = decim_q;
    settle_d = settle_q;
    avgn_d   = avgn_q;
    avgen_d  = avgen_q;
    chan_d   = chan_q;
    if (wr_en) begin
      case (addr)
        A_MODE:   mode_d   = wdata;
        A_DECIM:  decim_d  = wdata;
        A_SETTLE: settle_d = wdata;
        A_AVGN:   avgn_d   = wdata;
        A_AVGEN:  avgen_d  = wdata[DATA_W-1];
        A_CHAN:   if (chan_ok) chan_d = wdata[CH_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      decim_q  <= '0;
      settle_q <= '0;
      avgn_q   <= '0;
      avgen_q  <= 1'b0;
      chan_q   <= '0;
    end else if (wr_en) begin
      mode_q   <= mode_d;
      decim_q  <= decim_d;
      settle_q <= settle_d;
      avgn_q   <= avgn_d;
      avgen_q  <= avgen_d;
      chan_q   <= chan_d;
    end
  end
endmodule

// File: rtl/cadc_conv_ctrl.sv
module cadc_conv_ctrl #(
  parameter int CODE_W = 16,
  parameter int AVG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              en_bit,
  input  logic              req_wr,
  input  logic [AVG_W-1:0]  avg_log2,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  output logic              en_q,
  output logic              pend_q,
  output logic              eoc_q,
  output logic [CODE_W-1:0] result_q,
  output logic              conv_start,
  output logic              irq
);
  localparam int MAXN  = (1 << AVG_W) - 1;
  localparam int CNT_W = MAXN + 1;
  localparam int ACC_W = CODE_W + MAXN;

  logic              en_d, pend_d, eoc_d, start_d, irq_d;
  logic [CODE_W-1:0] result_d;
  logic [ACC_W-1:0]  acc_q, acc_d, sum;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last_idx;
  logic [AVG_W-1:0]  n_q, n_d;

  always_comb begin
    sum      = acc_q + ACC_W'(conv_code);
    last_idx = (CNT_W'(1) << n_q) - CNT_W'(1);
  end

  always_comb begin
    en_d     = en_q;
    pend_d   = pend_q;
    eoc_d    = eoc_q;
    result_d = result_q;
    acc_d    = acc_q;
    cnt_d    = cnt_q;
    n_d      = n_q;
    start_d  = 1'b0;
    irq_d    = 1'b0;
    if (en_wr && !en_bit) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
      eoc_d  = 1'b0;
    end else begin
      if (en_wr) en_d = 1'b1;
      if (req_wr && en_q && !pend_q) begin
        pend_d  = 1'b1;
        eoc_d   = 1'b0;
        acc_d   = '0;
        cnt_d   = '0;
        n_d     = avg_log2;
        start_d = 1'b1;
      end else if (pend_q && conv_done) begin
        if (cnt_q == last_idx) begin
          pend_d   = 1'b0;
          eoc_d    = 1'b1;
          irq_d    = 1'b1;
          result_d = CODE_W'(sum >> n_q);
        end else begin
          acc_d   = sum;
          cnt_d   = cnt_q + CNT_W'(1);
          start_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      pend_q     <= 1'b0;
      eoc_q      <= 1'b0;
      result_q   <= '0;
      acc_q      <= '0;
      cnt_q      <= '0;
      n_q        <= '0;
      conv_start <= 1'b0;
      irq        <= 1'b0;
    end else begin
      en_q       <= en_d;
      pend_q     <= pend_d;
      eoc_q      <= eoc_d;
      result_q   <= result_d;
      acc_q      <= acc_d;
      cnt_q      <= cnt_d;
      n_q        <= n_d;
      conv_start <= start_d;
      irq        <= irq_d;
    end
  end
endmodule

// File: rtl/cadc_guard.sv
module cadc_guard
  import cadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed_q,
  output logic [DATA_W-1:0] prot_q
);
  logic              armed_d;
  logic [DATA_W-1:0] prot_d;

  always_comb begin
    armed_d = armed_q;
    prot_d  = prot_q;
    if (wr_en) begin
      armed_d = (addr == A_KEY) && (wdata == KEY_VALUE);
      if (addr == A_PROT && armed_q) prot_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prot_q  <= '0;
    end else if (wr_en) begin
      armed_q <= armed_d;
      prot_q  <= prot_d;
    end
  end
endmodule

// File: rtl/cadc_regbank.sv
module cadc_regbank
  import cadc_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int AVG_W  = 3,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  output logic              irq
);
  logic [DATA_W-1:0] mode_q, decim_q, settle_q, avgn_q, prot_q;
  logic              avgen_q, en_q, pend_q, eoc_q, armed_q;
  logic [CH_W-1:0]   chan_q;
  logic [CODE_W-1:0] result_q;
  logic [AVG_W-1:0]  avg_log2;
  logic              en_wr, req_wr;

  always_comb begin
    en_wr    = wr_en && (addr == A_ENABLE);
    req_wr   = wr_en && (addr == A_REQ) && wdata[DATA_W-1];
    avg_log2 = avgen_q ? avgn_q[AVG_W-1:0] : '0;
  end

  cadc_cfg_regs #(.CH_W(CH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_q(mode_q), .decim_q(decim_q), .settle_q(settle_q),
    .avgn_q(avgn_q), .avgen_q(avgen_q), .chan_q(chan_q)
  );

  cadc_conv_ctrl #(.CODE_W(CODE_W), .AVG_W(AVG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_bit(wdata[DATA_W-1]),
    .req_wr(req_wr), .avg_log2(avg_log2), .conv_done(conv_done),
    .conv_code(conv_code), .en_q(en_q), .pend_q(pend_q), .eoc_q(eoc_q),
    .result_q(result_q), .conv_start(conv_start), .irq(irq)
  );

  cadc_guard u_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .armed_q(armed_q), .prot_q(prot_q)
  );

  always_comb begin
    case (addr)
      A_REV:     rdata = ID_REV;
      A_TYPE:    rdata = ID_TYPE;
      A_SUBTYPE: rdata = ID_SUBTYPE;
      A_STATUS:  rdata = {1'b0, mode_q[5:3], 2'b00, pend_q, eoc_q};
      A_MODE:    rdata = mode_q;
      A_ENABLE:  rdata = {en_q, 7'b0};
      A_CHAN:    rdata = DATA_W'(chan_q);
      A_DECIM:   rdata = decim_q;
      A_SETTLE:  rdata = settle_q;
      A_REQ:     rdata = {pend_q, 7'b0};
      A_AVGN:    rdata = avgn_q;
      A_AVGEN:   rdata = {avgen_q, 7'b0};
      A_RES_LO:  rdata = result_q[7:0];
      A_RES_HI:  rdata = result_q[15:8];
      A_PROT:    rdata = prot_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/cadc_regbank_chk.sv
module cadc_regbank_chk
  import cadc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              conv_start,
  input logic              irq,
  input logic              en_q,
  input logic              pend_q,
  input logic              eoc_q,
  input logic              armed_q,
  input logic [DATA_W-1:0] prot_q
);
  // R1
  id_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_TYPE) |-> (rdata == ID_TYPE));

  // R5
  pend_eoc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && eoc_q));

  // R6
  start_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> pend_q);

  // R9
  irq_with_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (eoc_q && !pend_q));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R10
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!pend_q && !eoc_q));

  // R12
  prot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_q) |-> $past(armed_q && wr_en && addr == A_PROT));
endmodule

bind cadc_regbank cadc_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .conv_start(conv_start), .irq(irq), .en_q(en_q), .pend_q(pend_q),
  .eoc_q(eoc_q), .armed_q(armed_q), .prot_q(prot_q)
);

// File: tb/tb_cadc_regbank.sv
`timescale 1ns/1ps
module tb_cadc_regbank;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        conv_start;
  logic        conv_done;
  logic [15:0] conv_code;
  logic        irq;

  int n_chk, n_bad;
  int start_cnt, irq_cnt, irq_run, irq_max;
  logic [15:0] base_code, step_code;
  int k_smp;
  logic stub_busy;
  int stub_cnt;

  cadc_regbank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .conv_start(conv_start), .conv_done(conv_done),
    .conv_code(conv_code), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // converter model: answers each start after several cycles
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) start_cnt <= start_cnt + 1;
    if (irq) begin
      irq_cnt <= irq_cnt + 1;
      irq_run <= irq_run + 1;
      if (irq_run + 1 > irq_max) irq_max <= irq_run + 1;
    end else irq_run <= 0;
    if (stub_busy) begin
      if (stub_cnt == 0) begin
        conv_done <= 1'b1;
        conv_code <= base_code + 16'(k_smp) * step_code;
        k_smp     <= k_smp + 1;
        stub_busy <= 1'b0;
      end else stub_cnt <= stub_cnt - 1;
    end else if (conv_start) begin
      stub_busy <= 1'b1;
      stub_cnt  <= 6;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_eoc();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      bus_read(8'h08, s);
      if (s[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R2 irq", 32'(irq), 0);
    chk("R2 conv_start", 32'(conv_start), 0);
    bus_read(8'h08, v); chk("R2 status", 32'(v), 0);
    bus_read(8'h46, v); chk("R2 enable", 32'(v), 0);
    bus_read(8'h48, v); chk("R2 chan", 32'(v), 0);
    bus_read(8'h60, v); chk("R2 res lo", 32'(v), 0);
    bus_read(8'h61, v); chk("R2 res hi", 32'(v), 0);
    bus_read(8'hDA, v); chk("R2 prot", 32'(v), 0);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    bus_read(8'h01, v); chk("R1 rev", 32'(v), 32'h01);
    bus_read(8'h04, v); chk("R1 type", 32'(v), 32'h08);
    bus_read(8'h05, v); chk("R1 subtype", 32'(v), 32'h03);
    bus_write(8'h04, 8'hFF);
    bus_write(8'h01, 8'h00);
    bus_read(8'h04, v); chk("R1 type after write", 32'(v), 32'h08);
    bus_read(8'h01, v); chk("R1 rev after write", 32'(v), 32'h01);
    bus_write(8'h30, 8'h5C);
    bus_read(8'h30, v); chk("R13 undefined", 32'(v), 0);
    bus_read(8'hFF, v); chk("R13 undefined top", 32'(v), 0);
  endtask

  task automatic t_cfg();
    logic [7:0] v;
    bus_write(8'h40, 8'h29);
    bus_read(8'h40, v); chk("R3 mode", 32'(v), 32'h29);
    bus_read(8'h08, v); chk("R5 status mode field", 32'(v), 32'h50);
    bus_write(8'h50, 8'h0C); bus_read(8'h50, v); chk("R3 decim", 32'(v), 32'h0C);
    bus_write(8'h51, 8'h7E); bus_read(8'h51, v); chk("R3 settle", 32'(v), 32'h7E);
    bus_write(8'h5A, 8'h03); bus_read(8'h5A, v); chk("R3 avg exp", 32'(v), 32'h03);
    bus_write(8'h5B, 8'hFF); bus_read(8'h5B, v); chk("R3 avg on", 32'(v), 32'h80);
    bus_write(8'h5B, 8'h7F); bus_read(8'h5B, v); chk("R3 avg off", 32'(v), 32'h00);
    bus_write(8'h40, 8'h01);
    bus_read(8'h08, v); chk("R5 status normal", 32'(v), 0);
  endtask

  task automatic t_chan();
    logic [7:0] v;
    bus_write(8'h48, 8'h05); bus_read(8'h48, v); chk("R4 chan 5", 32'(v), 5);
    bus_write(8'h48, 8'h02); bus_read(8'h48, v); chk("R4 chan 2 rejected", 32'(v), 5);
    bus_write(8'h48, 8'h06); bus_read(8'h48, v); chk("R4 chan 6", 32'(v), 6);
    bus_write(8'h48, 8'h81); bus_read(8'h48, v); chk("R4 chan 0x81 rejected", 32'(v), 6);
    bus_write(8'h48, 8'h07); bus_read(8'h48, v); chk("R4 chan 7 rejected", 32'(v), 6);
    bus_write(8'h48, 8'h03); bus_read(8'h48, v); chk("R4 chan 3", 32'(v), 3);
  endtask

  task automatic t_disabled_req();
    logic [7:0] v;
    int s0;
    s0 = start_cnt;
    bus_write(8'h52, 8'h80);
    repeat (12) @(negedge clk);
    chk("R7 no start while off", 32'(start_cnt - s0), 0);
    bus_read(8'h08, v); chk("R7 status unchanged", 32'(v), 0);
  endtask

  task automatic run_conv(input string tag, input logic [15:0] b, input logic [15:0] st,
                          input int nsmp, input logic [15:0] exp_res);
    logic [7:0] v;
    int s0, i0;
    base_code = b; step_code = st; k_smp = 0;
    s0 = start_cnt; i0 = irq_cnt;
    bus_write(8'h52, 8'h80);
    bus_read(8'h08, v); chk({tag, " R6 pending"}, 32'(v), 32'h02);
    bus_read(8'h52, v); chk({tag, " R6 req readback"}, 32'(v), 32'h80);
    bus_write(8'h52, 8'h80);
    wait_eoc();
    repeat (2) @(negedge clk);
    bus_read(8'h08, v); chk({tag, " R8 status done"}, 32'(v), 32'h01);
    bus_read(8'h60, v); chk({tag, " R11 res lo"}, 32'(v), 32'(exp_res[7:0]));
    bus_read(8'h61, v); chk({tag, " R11 res hi"}, 32'(v), 32'(exp_res[15:8]));
    chk({tag, " R8 start count"}, 32'(start_cnt - s0), 32'(nsmp));
    chk({tag, " R9 irq count"}, 32'(irq_cnt - i0), 1);
  endtask

  task automatic t_convert();
    logic [7:0] v;
    bus_write(8'h46, 8'h80);
    bus_read(8'h46, v); chk("R3 enable", 32'(v), 32'h80);
    run_conv("single", 16'h1234, 16'h0000, 1, 16'h1234);
    bus_write(8'h5A, 8'h02); bus_write(8'h5B, 8'h80);
    run_conv("avg4", 16'h1000, 16'h0011, 4, 16'h1019);
    bus_write(8'h5A, 8'h03);
    run_conv("avg8", 16'h0100, 16'h0001, 8, 16'h0103);
    bus_write(8'h5B, 8'h00);
    run_conv("avgoff", 16'hBEEF, 16'h0005, 1, 16'hBEEF);
    chk("R9 irq width", 32'(irq_max), 1);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    int i0;
    bus_write(8'h46, 8'h00);
    bus_read(8'h08, v); chk("R10 eoc cleared by off", 32'(v), 0);
    bus_write(8'h46, 8'h80);
    base_code = 16'h7777; step_code = 0; k_smp = 0;
    i0 = irq_cnt;
    bus_write(8'h52, 8'h80);
    bus_write(8'h46, 8'h00);
    bus_read(8'h08, v); chk("R10 pending cleared", 32'(v), 0);
    repeat (20) @(negedge clk);
    bus_read(8'h08, v); chk("R10 late done ignored status", 32'(v), 0);
    bus_read(8'h61, v); chk("R10 result kept hi", 32'(v), 32'hBE);
    bus_read(8'h60, v); chk("R10 result kept lo", 32'(v), 32'hEF);
    chk("R10 no irq", 32'(irq_cnt - i0), 0);
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    bus_write(8'hDA, 8'h04);
    bus_read(8'hDA, v); chk("R12 no key", 32'(v), 0);
    bus_write(8'hD0, 8'hA5); bus_write(8'hDA, 8'h04);
    bus_read(8'hDA, v); chk("R12 keyed write", 32'(v), 32'h04);
    bus_write(8'hDA, 8'hFF);
    bus_read(8'hDA, v); chk("R12 key single use", 32'(v), 32'h04);
    bus_write(8'hD0, 8'hA5); bus_write(8'h51, 8'h11); bus_write(8'hDA, 8'hFF);
    bus_read(8'hDA, v); chk("R12 key consumed by other write", 32'(v), 32'h04);
    bus_write(8'hD0, 8'h5A); bus_write(8'hDA, 8'hFF);
    bus_read(8'hDA, v); chk("R12 wrong key", 32'(v), 32'h04);
    bus_write(8'hD0, 8'hA5); bus_write(8'hD0, 8'hA5); bus_write(8'hDA, 8'h00);
    bus_read(8'hDA, v); chk("R12 re-armed key", 32'(v), 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; start_cnt = 0; irq_cnt = 0; irq_run = 0; irq_max = 0;
    base_code = 0; step_code = 0; k_smp = 0; stub_busy = 1'b0; stub_cnt = 0;
    conv_done = 1'b0; conv_code = '0;
    wr_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ids();
    t_cfg();
    t_chan();
    t_disabled_req();
    t_convert();
    t_abort();
    t_unlock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule